// File: doc/BRIEF.md
# FPGA Configuration Reset Sequencer

This block drives the two active-low reset lines of an FPGA configuration manager, a soft reset and a hard reset, in a fixed order. The soft reset always goes low first. After a fixed number of clock cycles the hard reset joins it. Both lines are then held low for a minimum wall-clock time, which is turned into a cycle count from the clock-frequency parameter. At the end both lines are released on the same clock edge. A soft-only variant asserts the soft reset alone for the lead interval and never touches the hard reset.

A sequence can be started in two ways. The first is a pair of active-low request pins, each passed through a synchronizer. The second is a single-cycle write of a 32-bit trigger word. Each 16-bit half of the trigger word is armed only by its own magic value. The clock must keep running from the start of a sequence to its end. A `busy` output is high for the whole of each sequence, and any request that arrives during a sequence is dropped.

Top module: `fpga_rst_seq`

## Requirements
- R1: After `rst_n` is released, `softRstN` and `hardRstN` are both 1 and `busy` is 0 until a start request arrives.
- R2: A write whose data has bits [31:16] = 0xB007 and bits [15:0] = 0x50F7 starts the full sequence. `softRstN` goes low on the clock edge that samples the write, and `hardRstN` goes low exactly LEAD_CYCLES (default 100) cycles later.
- R3: In the full sequence `hardRstN` stays low for HOLD_CYCLES = ceil(HOLD_NS × CLK_HZ / 1e9) cycles, which is 750 with the defaults (3000 ns at 250 MHz). Both lines then return to 1 on the same edge.
- R4: A write with bits [15:0] = 0x50F7 and bits [31:16] not equal to 0xB007 drives `softRstN` low for exactly LEAD_CYCLES cycles and leaves `hardRstN` at 1 throughout.
- R5: A write with bits [15:0] not equal to 0x50F7 has no effect, whatever bits [31:16] hold.
- R6: `busy` is 1 exactly while at least one reset output is low.
- R7: While `busy` is 1, writes and pin requests are ignored. They neither extend nor alter the running sequence, and they do not start a new sequence after it ends.
- R8: `extHardReqN` held low while idle starts the full sequence. After SYNC_STAGES (default 2) synchronizer edges, `softRstN` falls on the following edge. If a full request and a soft-only request arrive in the same cycle, the full request wins.
- R9: `extSoftReqN` held low while idle, with no full request pending, starts the soft-only sequence after the same synchronizer delay.
- R10: `hardRstN` is never low while `softRstN` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; must run throughout a sequence |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer itself |
| extSoftReqN | input | 1 | Active-low asynchronous soft-only request pin |
| extHardReqN | input | 1 | Active-low asynchronous full-sequence request pin |
| regWrEn | input | 1 | Single-cycle write strobe for the trigger word |
| regWrData | input | 32 | Trigger word: [31:16] hard key, [15:0] soft key |
| softRstN | output | 1 | Active-low soft reset output |
| hardRstN | output | 1 | Active-low hard reset output |
| busy | output | 1 | High while a sequence is running |

## Verification
A wrong state or counter value inside this block shows up directly at the outputs. It appears as a misplaced falling edge on `hardRstN`, a hold interval that is too short or too long, the two lines releasing on different edges, or `busy` disagreeing with the reset lines. The bench records, cycle by cycle, the first and last low cycle of each output. Any single-cycle error in the lead or hold counts is therefore reported within one sequence, which is at most about 850 cycles. A control state that reacts to requests during a run is exposed because the reset lines change at the ports within a few cycles of the ignored request.

// File: rtl/fpga_rst_seq_pkg.sv
package fpga_rst_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_SOFT_ONLY = 2'd1,
    ST_SOFT_LEAD = 2'd2,
    ST_BOTH      = 2'd3
  } seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic loadLead;
    logic loadHold;
  } cntStrobe_t;

  // datapath -> control decoded start requests
  typedef struct packed {
    logic full;
    logic softOnly;
  } startReq_t;

endpackage

// File: rtl/fpga_rst_seq_dp.sv
module fpga_rst_seq_dp
  import fpga_rst_seq_pkg::*;
#(
  parameter int KEY_W       = 16,
  parameter logic [KEY_W-1:0] HARD_KEY = 16'hB007,
  parameter logic [KEY_W-1:0] SOFT_KEY = 16'h50F7,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 10,
  parameter int LEAD_LOAD   = 99,
  parameter int HOLD_LOAD   = 749
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               extSoftReqN,
  input  logic               extHardReqN,
  input  logic               regWrEn,
  input  logic [2*KEY_W-1:0] regWrData,
  input  cntStrobe_t         strobe,
  output startReq_t          req,
  output logic               cntDone
);

  localparam int REG_W = 2 * KEY_W;

  // Pin synchronizers: index 0 = soft pin, 1 = hard pin
  logic [1:0] pinRaw;
  logic [1:0] pinSync;
  assign pinRaw = {extHardReqN, extSoftReqN};

  for (genvar p = 0; p < 2; p++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else if (SYNC_STAGES == 1) chain <= pinRaw[p];
      else chain <= {chain[SYNC_STAGES-2:0], pinRaw[p]};
    end
    assign pinSync[p] = chain[SYNC_STAGES-1];
  end

  // Key decode
  logic hardKeyOk;
  logic softKeyOk;
  assign hardKeyOk = (regWrData[REG_W-1:KEY_W] == HARD_KEY);
  assign softKeyOk = (regWrData[KEY_W-1:0] == SOFT_KEY);

  logic wrFull;
  logic wrSoft;
  assign wrFull = regWrEn && hardKeyOk && softKeyOk;
  assign wrSoft = regWrEn && softKeyOk && !hardKeyOk;

  always_comb begin
    req.full     = !pinSync[1] || wrFull;
    req.softOnly = !req.full && (!pinSync[0] || wrSoft);
  end

  // Interval counter
  logic [CNT_W-1:0] cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (strobe.loadLead) cnt <= CNT_W'(LEAD_LOAD);
    else if (strobe.loadHold) cnt <= CNT_W'(HOLD_LOAD);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end
  assign cntDone = (cnt == '0);

endmodule

// File: rtl/fpga_rst_seq_ctrl.sv
module fpga_rst_seq_ctrl
  import fpga_rst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  startReq_t  req,
  input  logic       cntDone,
  output cntStrobe_t strobe,
  output logic       softRstN,
  output logic       hardRstN,
  output logic       busy
);

  seqState_t state;
  seqState_t stateNext;

  always_comb begin
    stateNext       = state;
    strobe.loadLead = 1'b0;
    strobe.loadHold = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (req.full) begin
          stateNext       = ST_SOFT_LEAD;
          strobe.loadLead = 1'b1;
        end else if (req.softOnly) begin
          stateNext       = ST_SOFT_ONLY;
          strobe.loadLead = 1'b1;
        end
      end
      ST_SOFT_LEAD: begin
        if (cntDone) begin
          stateNext       = ST_BOTH;
          strobe.loadHold = 1'b1;
        end
      end
      ST_BOTH:      if (cntDone) stateNext = ST_IDLE;
      ST_SOFT_ONLY: if (cntDone) stateNext = ST_IDLE;
      default:      stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      softRstN <= 1'b1;
      hardRstN <= 1'b1;
      busy     <= 1'b0;
    end else begin
      state    <= stateNext;
      softRstN <= (stateNext == ST_IDLE);
      hardRstN <= (stateNext != ST_BOTH);
      busy     <= (stateNext != ST_IDLE);
    end
  end

endmodule

// File: rtl/fpga_rst_seq.sv
module fpga_rst_seq
  import fpga_rst_seq_pkg::*;
#(
  parameter int CLK_HZ      = 250_000_000,
  parameter int HOLD_NS     = 3000,
  parameter int LEAD_CYCLES = 100,
  parameter int SYNC_STAGES = 2,
  parameter int KEY_W       = 16,
  parameter logic [KEY_W-1:0] HARD_KEY = 16'hB007,
  parameter logic [KEY_W-1:0] SOFT_KEY = 16'h50F7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               extSoftReqN,
  input  logic               extHardReqN,
  input  logic               regWrEn,
  input  logic [2*KEY_W-1:0] regWrData,
  output logic               softRstN,
  output logic               hardRstN,
  output logic               busy
);

  localparam longint unsigned HOLD_PROD = longint'(HOLD_NS) * longint'(CLK_HZ);
  localparam int HOLD_RAW    = int'((HOLD_PROD + 64'd999_999_999) / 64'd1_000_000_000);
  localparam int HOLD_CYCLES = (HOLD_RAW < 1) ? 1 : HOLD_RAW;
  localparam int MAX_CYCLES  = (HOLD_CYCLES > LEAD_CYCLES) ? HOLD_CYCLES : LEAD_CYCLES;
  localparam int CNT_W       = $clog2(MAX_CYCLES + 1);

  cntStrobe_t strobe;
  startReq_t  req;
  logic       cntDone;

  fpga_rst_seq_dp #(
    .KEY_W      (KEY_W),
    .HARD_KEY   (HARD_KEY),
    .SOFT_KEY   (SOFT_KEY),
    .SYNC_STAGES(SYNC_STAGES),
    .CNT_W      (CNT_W),
    .LEAD_LOAD  (LEAD_CYCLES - 1),
    .HOLD_LOAD  (HOLD_CYCLES - 1)
  ) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .extSoftReqN(extSoftReqN),
    .extHardReqN(extHardReqN),
    .regWrEn    (regWrEn),
    .regWrData  (regWrData),
    .strobe     (strobe),
    .req        (req),
    .cntDone    (cntDone)
  );

  fpga_rst_seq_ctrl ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .cntDone (cntDone),
    .strobe  (strobe),
    .softRstN(softRstN),
    .hardRstN(hardRstN),
    .busy    (busy)
  );

endmodule

// File: rtl/fpga_rst_seq_chk.sv
module fpga_rst_seq_chk #(
  parameter int LEAD_CYCLES = 100,
  parameter int HOLD_CYCLES = 750
) (
  input logic clk,
  input logic rst_n,
  input logic softRstN,
  input logic hardRstN,
  input logic busy
);

  // cycles with soft low and hard high (held while hard is low)
  logic [31:0] leadCnt;
  // cycles with hard low
  logic [31:0] holdCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      leadCnt <= '0;
      holdCnt <= '0;
    end else begin
      if (softRstN) leadCnt <= '0;
      else if (hardRstN) leadCnt <= leadCnt + 1;
      if (hardRstN) holdCnt <= '0;
      else holdCnt <= holdCnt + 1;
    end
  end

  AST_HARD_AFTER_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
    !hardRstN |-> !softRstN); // R10

  AST_BUSY_TRACKS_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (!softRstN || !hardRstN)); // R6

  AST_LEAD_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hardRstN) |-> (leadCnt == 32'(LEAD_CYCLES))); // R2

  AST_HOLD_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hardRstN) |-> (holdCnt == 32'(HOLD_CYCLES))); // R3

  AST_JOINT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hardRstN) |-> $rose(softRstN)); // R3

endmodule

bind fpga_rst_seq fpga_rst_seq_chk #(
  .LEAD_CYCLES(LEAD_CYCLES),
  .HOLD_CYCLES(HOLD_CYCLES)
) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .softRstN(softRstN),
  .hardRstN(hardRstN),
  .busy    (busy)
);

// File: tb/fpga_rst_seq_tb_top.sv
`timescale 1ns/1ps
module fpga_rst_seq_tb_top;

  localparam int LEAD = 100;
  localparam int HOLD = 750;   // ceil(3000 ns * 250 MHz)
  localparam int LIMIT = 1200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic extSoftReqN = 1'b1;
  logic extHardReqN = 1'b1;
  logic regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic softRstN, hardRstN, busy;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fpga_rst_seq dut_i (
    .clk(clk), .rst_n(rst_n), .extSoftReqN(extSoftReqN), .extHardReqN(extHardReqN),
    .regWrEn(regWrEn), .regWrData(regWrData),
    .softRstN(softRstN), .hardRstN(hardRstN), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Records the run; index 'startIdx' is the current negedge.
  int softFirst, softLast, hardFirst, hardLast, badOrder, busyMis;
  task automatic measure(input int startIdx);
    softFirst = -1; softLast = -1; hardFirst = -1; hardLast = -1;
    badOrder = 0; busyMis = 0;
    for (int i = startIdx; i <= LIMIT; i++) begin
      if (!softRstN) begin if (softFirst < 0) softFirst = i; softLast = i; end
      if (!hardRstN) begin if (hardFirst < 0) hardFirst = i; hardLast = i; end
      if (!hardRstN && softRstN) badOrder++;
      if (busy != (!softRstN || !hardRstN)) busyMis++;
      if (i > startIdx + 2 && !busy) break;
      @(negedge clk);
    end
  endtask

  task automatic writeWord(input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic checkIdle(input string req);
    chk(softRstN === 1'b1, req, int'(softRstN), 1);
    chk(hardRstN === 1'b1, req, int'(hardRstN), 1);
    chk(busy === 1'b0, req, int'(busy), 0);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checkIdle("R1");
    repeat (5) @(negedge clk);
    checkIdle("R1");
  endtask

  task automatic testFullWrite();
    writeWord(32'hB007_50F7);
    measure(1);
    chk(softFirst == 1, "R2 soft start", softFirst, 1);
    chk(hardFirst == 1 + LEAD, "R2 hard start", hardFirst, 1 + LEAD);
    chk(hardLast - hardFirst + 1 == HOLD, "R3 hold length", hardLast - hardFirst + 1, HOLD);
    chk(softLast == hardLast, "R3 joint release", softLast, hardLast);
    chk(badOrder == 0, "R10 order", badOrder, 0);
    chk(busyMis == 0, "R6 busy", busyMis, 0);
    checkIdle("R3");
  endtask

  task automatic testSoftWrite();
    writeWord(32'hB006_50F7);
    measure(1);
    chk(softFirst == 1, "R4 soft start", softFirst, 1);
    chk(softLast == LEAD, "R4 soft end", softLast, LEAD);
    chk(hardFirst == -1, "R4 hard untouched", hardFirst, -1);
    chk(busyMis == 0, "R6 busy", busyMis, 0);
  endtask

  task automatic testBadKeys();
    logic [31:0] words [3] = '{32'hB007_0000, 32'hB007_50F6, 32'h1234_5678};
    foreach (words[k]) begin
      writeWord(words[k]);
      repeat (3) @(negedge clk);
      checkIdle("R5");
    end
  endtask

  task automatic testBusyIgnore();
    writeWord(32'h0000_50F7);
    repeat (39) @(negedge clk);  // index 40
    regWrEn = 1'b1; regWrData = 32'hB007_50F7; extHardReqN = 1'b0; extSoftReqN = 1'b0;
    @(negedge clk);               // index 41
    regWrEn = 1'b0; regWrData = '0; extHardReqN = 1'b1; extSoftReqN = 1'b1;
    measure(41);
    chk(softLast == LEAD, "R7 soft end unchanged", softLast, LEAD);
    chk(hardFirst == -1, "R7 hard untouched", hardFirst, -1);
    repeat (6) @(negedge clk);
    checkIdle("R7");
  endtask

  task automatic testHardPin();
    @(negedge clk);
    extHardReqN = 1'b0;
    @(negedge clk);
    extHardReqN = 1'b1;
    measure(1);
    chk(softFirst == 3, "R8 sync latency", softFirst, 3);
    chk(hardFirst == 3 + LEAD, "R8 hard start", hardFirst, 3 + LEAD);
    chk(softLast == hardLast, "R8 joint release", softLast, hardLast);
    chk(badOrder == 0, "R10 order", badOrder, 0);
  endtask

  task automatic testSoftPin();
    @(negedge clk);
    extSoftReqN = 1'b0;
    @(negedge clk);
    extSoftReqN = 1'b1;
    measure(1);
    chk(softFirst == 3, "R9 sync latency", softFirst, 3);
    chk(softLast == 2 + LEAD, "R9 soft end", softLast, 2 + LEAD);
    chk(hardFirst == -1, "R9 hard untouched", hardFirst, -1);
  endtask

  task automatic testPriority();
    @(negedge clk);
    extSoftReqN = 1'b0; extHardReqN = 1'b0;
    @(negedge clk);
    extSoftReqN = 1'b1; extHardReqN = 1'b1;
    measure(1);
    chk(hardFirst == 3 + LEAD, "R8 full wins", hardFirst, 3 + LEAD);
  endtask

  initial begin
    testReset();
    testFullWrite();
    testSoftWrite();
    testBadKeys();
    testBusyIgnore();
    testHardPin();
    testSoftPin();
    testPriority();
    repeat (4) @(negedge clk);
    finishRun();
  end

  initial begin
    #(200000 * 4);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

endmodule